// File: doc/BRIEF.md
# Accumulator CPU Control Sequencer

This block sequences a small accumulator processor. A 4-bit state register walks through sixteen fixed states that cover power-up clearing, a four-step instruction fetch, opcode dispatch, and the load, store, add and branch-if-negative routines. Each state turns on a fixed set of datapath and memory control lines. The outputs are decoded from the current state alone, so they change only at a clock edge.

Memory accesses use a stall handshake. In each read state the block raises the read request and the MBR capture strobe together, and stays in that state while the wait input is high. The MBR therefore reloads from the memory bus on every edge of the stall. The edge that leaves the state is also the last capture, so it stores the final, valid bus value. The external soft reset and the wait input can each pass through a single synchronizing flop, chosen by the `SYNC_INPUTS` parameter. The datapath registers and the memory are not part of the block.

Top module: `cpu_ctrl_fsm`

## Requirements
- R1: The state is observable on `state_o` with these codes: RES=1110, IF0=0000, IF1=1011, IF2=1111, IF3=1101, OD=0001, LD0=0010, LD1=0011, LD2=0100, ST0=0101, ST1=0110, AD0=0111, AD1=1000, AD2=1001, BR0=1010, BR1=1100.
- R2: While `rst_ni` is low the state is RES. When the soft reset seen by the machine is high, the next edge enters RES from any state, and the machine stays in RES while it remains high.
- R3: RES asserts pc_clr, ac_clr and ir_clr. RES then moves to IF0.
- R4: Fetch runs IF0 (mar_ld_pc) to IF1 (pc_inc) to IF2. IF2 leads to IF3 (ir_ld), and IF3 moves to OD.
- R5: IF2, LD1 and AD1 each assert mem_req, mem_rd, mar_drive and mbr_ld_mem. Each holds while the wait seen by the machine is high. When it is low, IF2 moves to IF3, LD1 to LD2 and AD1 to AD2.
- R6: ST0 asserts mar_ld_ir and mbr_ld_ac. ST1 asserts mem_req, mem_wr, mar_drive and mbr_drive. ST1 holds while the wait seen by the machine is high, then moves to IF0.
- R7: OD asserts nothing and dispatches on `ir_op_i`: 00 to LD0, 01 to ST0, 10 to AD0, 11 to BR0. `ir_op_i` has no effect in any other state.
- R8: BR0 asserts nothing. If `ac_sign_i` is 1 it moves to BR1 (pc_ld), which then goes to IF0. If `ac_sign_i` is 0 it goes straight to IF0. `ac_sign_i` has no effect in any other state.
- R9: LD0 and AD0 assert mar_ld_ir and move to LD1 and AD1 respectively. LD2 asserts ac_ld and alu_pass, and AD2 asserts ac_ld and alu_add. Both then move to IF0.
- R10: `ctrl_o` bit positions are 0 pc_clr, 1 pc_inc, 2 pc_ld, 3 mar_ld_pc, 4 mar_ld_ir, 5 mbr_ld_mem, 6 mbr_ld_ac, 7 mbr_drive, 8 ir_ld, 9 ac_ld, 10 alu_add, 11 alu_pass, 12 mem_req, 13 mem_rd, 14 mem_wr, 15 mar_drive, 16 ac_clr, 17 ir_clr. The outputs depend only on the state, and no more than four are set at once. mem_req, mar_drive and exactly one of mem_rd or mem_wr are always set together.
- R11: With `SYNC_INPUTS`=1, `reset_i` and `wait_i` each pass through one flop. Under `rst_ni`, the reset flop clears to 1 and the wait flop clears to 1. Suppose wait idles high and drops L cycles after the request appears. A read state then lasts L+2 cycles (L+1 without the flops).
- R12: Let the memory drive valid data once its wait is low. For latencies 0, 1 and 3, the MBR value present on the cycle after the exit edge of a read state equals the memory data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reset_i | input | 1 | Soft reset request to the processor |
| wait_i | input | 1 | Memory stall, high while the access is incomplete |
| ir_op_i | input | 2 | Opcode bits from the top of the instruction register |
| ac_sign_i | input | 1 | Accumulator sign bit |
| ctrl_o | output | 18 | Microoperation control lines, decoded from the state |
| state_o | output | 4 | Current state code |

## Verification
State and control outputs are due half a cycle after each edge. The bench compares them on every falling edge against a reference sequencer built from the requirements. Opcode and sign decisions show on the edge after OD or BR0. A soft reset or wait change lands two edges after it is driven, because of the synchronizer. Each read-state exit is checked on the falling edge after the exit edge: the MBR must hold the memory data and the dwell must be L+2. The opcode and sign inputs carry changing junk in every state other than OD and BR0, so any stray decode shows up in the per-cycle state comparison.

// File: rtl/cpu_ctrl_pkg.sv
package cpu_ctrl_pkg;

  localparam int STATE_W = 4;
  localparam int CTRL_W  = 18;
  localparam int OP_W    = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IF0 = 4'b0000,
    ST_OD  = 4'b0001,
    ST_LD0 = 4'b0010,
    ST_LD1 = 4'b0011,
    ST_LD2 = 4'b0100,
    ST_ST0 = 4'b0101,
    ST_ST1 = 4'b0110,
    ST_AD0 = 4'b0111,
    ST_AD1 = 4'b1000,
    ST_AD2 = 4'b1001,
    ST_BR0 = 4'b1010,
    ST_IF1 = 4'b1011,
    ST_BR1 = 4'b1100,
    ST_IF3 = 4'b1101,
    ST_RES = 4'b1110,
    ST_IF2 = 4'b1111
  } state_e;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_ADD   = 2'b10,
    OP_BRN   = 2'b11
  } op_e;

  typedef logic [CTRL_W-1:0] ctrl_t;

  localparam int C_PC_CLR     = 0;
  localparam int C_PC_INC     = 1;
  localparam int C_PC_LD      = 2;
  localparam int C_MAR_LD_PC  = 3;
  localparam int C_MAR_LD_IR  = 4;
  localparam int C_MBR_LD_MEM = 5;
  localparam int C_MBR_LD_AC  = 6;
  localparam int C_MBR_DRIVE  = 7;
  localparam int C_IR_LD      = 8;
  localparam int C_AC_LD      = 9;
  localparam int C_ALU_ADD    = 10;
  localparam int C_ALU_PASS   = 11;
  localparam int C_MEM_REQ    = 12;
  localparam int C_MEM_RD     = 13;
  localparam int C_MEM_WR     = 14;
  localparam int C_MAR_DRIVE  = 15;
  localparam int C_AC_CLR     = 16;
  localparam int C_IR_CLR     = 17;

  localparam int MAX_ACTIVE = 4;

endpackage

// File: rtl/cpu_ctrl_sync.sv
module cpu_ctrl_sync #(
  parameter bit           EN      = 1'b1,
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (EN) begin : g_flop
      logic [W-1:0] q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= RST_VAL;
        else         q_q <= d_i;
      end
      assign q_o = q_q;
    end else begin : g_pass
      assign q_o = d_i;
    end
  endgenerate

endmodule

// File: rtl/cpu_ctrl_next.sv
module cpu_ctrl_next
  import cpu_ctrl_pkg::*;
(
  input  state_e          state_i,
  input  logic            reset_i,
  input  logic            wait_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            sign_i,
  output state_e          next_o
);

  state_e seq_next;

  always_comb begin
    seq_next = ST_IF0;
    unique case (state_i)
      ST_RES: seq_next = ST_IF0;
      ST_IF0: seq_next = ST_IF1;
      ST_IF1: seq_next = ST_IF2;
      ST_IF2: seq_next = wait_i ? ST_IF2 : ST_IF3;
      ST_IF3: seq_next = ST_OD;
      ST_OD: begin
        unique case (op_e'(op_i))
          OP_LOAD:  seq_next = ST_LD0;
          OP_STORE: seq_next = ST_ST0;
          OP_ADD:   seq_next = ST_AD0;
          OP_BRN:   seq_next = ST_BR0;
          default:  seq_next = ST_LD0;
        endcase
      end
      ST_LD0: seq_next = ST_LD1;
      ST_LD1: seq_next = wait_i ? ST_LD1 : ST_LD2;
      ST_LD2: seq_next = ST_IF0;
      ST_ST0: seq_next = ST_ST1;
      ST_ST1: seq_next = wait_i ? ST_ST1 : ST_IF0;
      ST_AD0: seq_next = ST_AD1;
      ST_AD1: seq_next = wait_i ? ST_AD1 : ST_AD2;
      ST_AD2: seq_next = ST_IF0;
      ST_BR0: seq_next = sign_i ? ST_BR1 : ST_IF0;
      ST_BR1: seq_next = ST_IF0;
      default: seq_next = ST_RES;
    endcase
  end

  // soft reset overrides every transition
  assign next_o = reset_i ? ST_RES : seq_next;

endmodule

// File: rtl/cpu_ctrl_decode.sv
module cpu_ctrl_decode
  import cpu_ctrl_pkg::*;
(
  input  state_e state_i,
  output ctrl_t  ctrl_o
);

  ctrl_t rd_grp;
  ctrl_t wr_grp;

  always_comb begin
    rd_grp = '0;
    rd_grp[C_MEM_REQ]    = 1'b1;
    rd_grp[C_MEM_RD]     = 1'b1;
    rd_grp[C_MAR_DRIVE]  = 1'b1;
    rd_grp[C_MBR_LD_MEM] = 1'b1;
    wr_grp = '0;
    wr_grp[C_MEM_REQ]    = 1'b1;
    wr_grp[C_MEM_WR]     = 1'b1;
    wr_grp[C_MAR_DRIVE]  = 1'b1;
    wr_grp[C_MBR_DRIVE]  = 1'b1;
  end

  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      ST_RES: begin
        ctrl_o[C_PC_CLR] = 1'b1;
        ctrl_o[C_AC_CLR] = 1'b1;
        ctrl_o[C_IR_CLR] = 1'b1;
      end
      ST_IF0: ctrl_o[C_MAR_LD_PC] = 1'b1;
      ST_IF1: ctrl_o[C_PC_INC]    = 1'b1;
      ST_IF2: ctrl_o = rd_grp;
      ST_IF3: ctrl_o[C_IR_LD]     = 1'b1;
      ST_OD:  ctrl_o = '0;
      ST_LD0: ctrl_o[C_MAR_LD_IR] = 1'b1;
      ST_LD1: ctrl_o = rd_grp;
      ST_LD2: begin
        ctrl_o[C_AC_LD]    = 1'b1;
        ctrl_o[C_ALU_PASS] = 1'b1;
      end
      ST_ST0: begin
        ctrl_o[C_MAR_LD_IR] = 1'b1;
        ctrl_o[C_MBR_LD_AC] = 1'b1;
      end
      ST_ST1: ctrl_o = wr_grp;
      ST_AD0: ctrl_o[C_MAR_LD_IR] = 1'b1;
      ST_AD1: ctrl_o = rd_grp;
      ST_AD2: begin
        ctrl_o[C_AC_LD]   = 1'b1;
        ctrl_o[C_ALU_ADD] = 1'b1;
      end
      ST_BR0: ctrl_o = '0;
      ST_BR1: ctrl_o[C_PC_LD] = 1'b1;
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/cpu_ctrl_fsm.sv
module cpu_ctrl_fsm
  import cpu_ctrl_pkg::*;
#(
  parameter bit SYNC_INPUTS = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reset_i,
  input  logic                 wait_i,
  input  logic [OP_W-1:0]      ir_op_i,
  input  logic                 ac_sign_i,
  output logic [CTRL_W-1:0]    ctrl_o,
  output logic [STATE_W-1:0]   state_o
);

  logic   reset_s;
  logic   wait_s;
  state_e state_q;
  state_e state_d;

  cpu_ctrl_sync #(
    .EN      (SYNC_INPUTS),
    .W       (2),
    .RST_VAL (2'b11)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({reset_i, wait_i}),
    .q_o    ({reset_s, wait_s})
  );

  cpu_ctrl_next u_next (
    .state_i (state_q),
    .reset_i (reset_s),
    .wait_i  (wait_s),
    .op_i    (ir_op_i),
    .sign_i  (ac_sign_i),
    .next_o  (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RES;
    else         state_q <= state_d;
  end

  cpu_ctrl_decode u_dec (
    .state_i (state_q),
    .ctrl_o  (ctrl_o)
  );

  assign state_o = state_q;

endmodule

// File: rtl/cpu_ctrl_chk.sv
module cpu_ctrl_chk
  import cpu_ctrl_pkg::*;
#(
  parameter bit SYNC_INPUTS = 1'b1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wait_i,
  input logic                reset_s,
  input logic                wait_s,
  input logic                ac_sign_i,
  input logic [STATE_W-1:0]  state_q,
  input logic [CTRL_W-1:0]   ctrl_o
);

  logic in_mem;
  assign in_mem = (state_q == ST_IF2) || (state_q == ST_LD1) ||
                  (state_q == ST_AD1) || (state_q == ST_ST1);

  AST_RESET_TO_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_s |=> state_q == ST_RES); // R2

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_mem && wait_s && !reset_s |=> $stable(state_q)); // R5

  AST_FETCH_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IF2 && !wait_s && !reset_s |=> state_q == ST_IF3); // R5

  AST_READ_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[C_MEM_RD] |-> ctrl_o[C_MBR_LD_MEM]); // R5

  AST_DISPATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_OD && !reset_s |=>
      state_q inside {ST_LD0, ST_ST0, ST_AD0, ST_BR0}); // R7

  AST_BRANCH_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_BR0 && !reset_s && ac_sign_i |=> state_q == ST_BR1); // R8

  AST_BRANCH_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_BR0 && !reset_s && !ac_sign_i |=> state_q == ST_IF0); // R8

  AST_MOORE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(state_q) |-> $stable(ctrl_o)); // R10

  AST_MAX_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ctrl_o) <= MAX_ACTIVE); // R10

  AST_MEM_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[C_MEM_REQ] == (ctrl_o[C_MEM_RD] ^ ctrl_o[C_MEM_WR]) &&
    ctrl_o[C_MAR_DRIVE] == ctrl_o[C_MEM_REQ]); // R10

  generate
    if (SYNC_INPUTS) begin : g_sync_chk
      AST_WAIT_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> wait_s == $past(wait_i)); // R11
    end
  endgenerate

endmodule

bind cpu_ctrl_fsm cpu_ctrl_chk #(.SYNC_INPUTS(SYNC_INPUTS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wait_i    (wait_i),
  .reset_s   (reset_s),
  .wait_s    (wait_s),
  .ac_sign_i (ac_sign_i),
  .state_q   (state_q),
  .ctrl_o    (ctrl_o)
);

// File: tb/cpu_ctrl_fsm_bench.sv
`timescale 1ns/1ps
module cpu_ctrl_fsm_bench;

  localparam logic [3:0] S_IF0 = 4'b0000, S_IF1 = 4'b1011, S_IF2 = 4'b1111,
                         S_IF3 = 4'b1101, S_OD  = 4'b0001, S_LD0 = 4'b0010,
                         S_LD1 = 4'b0011, S_LD2 = 4'b0100, S_ST0 = 4'b0101,
                         S_ST1 = 4'b0110, S_AD0 = 4'b0111, S_AD1 = 4'b1000,
                         S_AD2 = 4'b1001, S_BR0 = 4'b1010, S_BR1 = 4'b1100,
                         S_RES = 4'b1110;
  localparam logic [15:0] MEM_WORD = 16'hC3A5;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        reset_i;
  logic        wait_i;
  logic [1:0]  ir_op_i;
  logic        ac_sign_i;
  logic [17:0] ctrl_o;
  logic [3:0]  state_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  cpu_ctrl_fsm #(.SYNC_INPUTS(1'b1)) u_cpu_ctrl_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .reset_i   (reset_i),
    .wait_i    (wait_i),
    .ir_op_i   (ir_op_i),
    .ac_sign_i (ac_sign_i),
    .ctrl_o    (ctrl_o),
    .state_o   (state_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [17:0] ref_ctrl(input logic [3:0] s);
    logic [17:0] c = '0;
    case (s)
      S_RES: begin c[0] = 1; c[16] = 1; c[17] = 1; end
      S_IF0: c[3] = 1;
      S_IF1: c[1] = 1;
      S_IF2, S_LD1, S_AD1: begin c[12] = 1; c[13] = 1; c[15] = 1; c[5] = 1; end
      S_IF3: c[8] = 1;
      S_LD0, S_AD0: c[4] = 1;
      S_LD2: begin c[9] = 1; c[11] = 1; end
      S_ST0: begin c[4] = 1; c[6] = 1; end
      S_ST1: begin c[12] = 1; c[14] = 1; c[15] = 1; c[7] = 1; end
      S_AD2: begin c[9] = 1; c[10] = 1; end
      S_BR1: c[2] = 1;
      default: c = '0;
    endcase
    return c;
  endfunction

  function automatic logic [3:0] ref_next(input logic [3:0] s, input logic rs,
                                          input logic wt, input logic [1:0] op,
                                          input logic sg);
    if (rs) return S_RES;
    case (s)
      S_RES: return S_IF0;
      S_IF0: return S_IF1;
      S_IF1: return S_IF2;
      S_IF2: return wt ? S_IF2 : S_IF3;
      S_IF3: return S_OD;
      S_OD:  return (op == 2'd0) ? S_LD0 : (op == 2'd1) ? S_ST0 :
                    (op == 2'd2) ? S_AD0 : S_BR0;
      S_LD0: return S_LD1;
      S_LD1: return wt ? S_LD1 : S_LD2;
      S_ST0: return S_ST1;
      S_ST1: return wt ? S_ST1 : S_IF0;
      S_AD0: return S_AD1;
      S_AD1: return wt ? S_AD1 : S_AD2;
      S_BR0: return sg ? S_BR1 : S_IF0;
      default: return S_IF0;
    endcase
  endfunction

  // memory model: wait idles high, drops lat cycles after the request appears
  int          lat = 0;
  int          cnt;
  logic [15:0] mbr_q;
  logic [3:0]  ref_state;
  logic        ref_rst_q, ref_wait_q;
  int          dwell;
  logic        exit_flag;
  int          cyc = 0;
  logic [1:0]  op_sel = 2'd0;
  logic        sign_sel = 1'b0;

  wire mem_req  = ctrl_o[12];
  wire mem_ok   = mem_req && (cnt >= lat);
  wire [15:0] bus = mem_ok ? MEM_WORD : (16'h0BAD ^ 16'(cnt));
  assign wait_i = !mem_ok;

  wire rd_state = (ref_state == S_IF2) || (ref_state == S_LD1) || (ref_state == S_AD1);

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= 0; mbr_q <= '0; ref_state <= S_RES;
      ref_rst_q <= 1'b1; ref_wait_q <= 1'b1; dwell <= 0; exit_flag <= 1'b0;
    end else begin
      cnt <= mem_req ? cnt + 1 : 0;
      if (ctrl_o[5]) mbr_q <= bus;
      ref_rst_q  <= reset_i;
      ref_wait_q <= wait_i;
      ref_state  <= ref_next(ref_state, ref_rst_q, ref_wait_q, ir_op_i, ac_sign_i);
      dwell      <= rd_state ? dwell + 1 : 0;
      exit_flag  <= rd_state && !ref_wait_q && !ref_rst_q;
    end
  end

  // junk on opcode and sign except where they are examined (R7, R8)
  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    ir_op_i   <= (ref_state == S_OD)  ? op_sel   : 2'(cyc ^ (cyc >> 2));
    ac_sign_i <= (ref_state == S_BR0) ? sign_sel : cyc[1];
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      check(state_o == ref_state, "R1 R4 R7 R8 state", 32'(state_o), 32'(ref_state));
      check(ctrl_o == ref_ctrl(ref_state), "R3 R5 R6 R9 R10 ctrl",
            32'(ctrl_o), 32'(ref_ctrl(ref_state)));
      if (exit_flag) begin
        check(mbr_q == MEM_WORD, "R12 mbr after exit", 32'(mbr_q), 32'(MEM_WORD));
        check(dwell == lat + 2, "R11 read dwell", 32'(dwell), 32'(lat + 2));
      end
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog expired act=%0d exp=%0d", 50000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run_instr(input logic [1:0] o, input logic s);
    int guard = 0;
    op_sel = o; sign_sel = s;
    while (ref_state != S_OD && guard < 100) begin @(negedge clk_i); guard++; end
    @(negedge clk_i);
    while (ref_state != S_IF0 && guard < 200) begin @(negedge clk_i); guard++; end
  endtask

  initial begin
    rst_ni = 1'b0; reset_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(state_o == S_RES, "R2 async reset state", 32'(state_o), 32'(S_RES));
    check(ctrl_o == ref_ctrl(S_RES), "R3 reset outputs", 32'(ctrl_o), 32'(ref_ctrl(S_RES)));
    rst_ni = 1'b1;
    foreach (lat_list[i]) begin
      lat = lat_list[i];
      for (int o = 0; o < 4; o++)
        for (int s = 0; s < 2; s++)
          run_instr(2'(o), 1'(s));
    end
    // soft reset during a stalled load (R2)
    lat = 3; op_sel = 2'd0;
    while (ref_state != S_LD1) @(negedge clk_i);
    reset_i = 1'b1;
    @(negedge clk_i);
    reset_i = 1'b0;
    check(state_o == S_LD1, "R2 reset not yet seen", 32'(state_o), 32'(S_LD1));
    @(negedge clk_i);
    check(state_o == S_RES, "R2 reset via sync flop", 32'(state_o), 32'(S_RES));
    @(negedge clk_i);
    check(state_o == S_IF0, "R3 res to fetch", 32'(state_o), 32'(S_IF0));
    run_instr(2'd2, 1'b1);
    run_instr(2'd3, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  int lat_list[3] = '{0, 1, 3};

endmodule